// File: doc/BRIEF.md
# Transmit Byte Queue with Programmable Fill Threshold

This block holds bytes waiting to be sent. A host-side port writes one byte per cycle. A modulator-side port removes one byte per cycle from the other end. The oldest unread byte is always visible on the read data output (show-ahead), so the consumer samples it in the same cycle that it asserts its read enable.

The block also reports on itself. It exposes the number of stored bytes, so that a status byte can carry the fill level. A 4-bit code selects one of sixteen fill levels, and a flag is raised while the count is at or above the selected level. Two sticky error flags are provided:

- An underflow flag records a read attempted while the queue was empty.
- An overflow flag records a write accepted while the queue was full.

Writes are never refused. A write into a full queue replaces the oldest unread byte. A synchronous flush input empties the queue and is the only way to clear the error flags.

Top module: `tx_fifo`

## Requirements
- R1: After the asynchronous reset is released, the count output is 0 and the threshold, underflow and overflow flags are all low.
- R2: Bytes leave in the order they were written, and `rd_data_o` always shows the oldest unread byte before it is consumed.
- R3: Each cycle the count changes as follows:
  - a write alone adds one;
  - an accepted read alone subtracts one;
  - a simultaneous write and read on a queue that holds between 1 and 63 bytes leaves it unchanged.
- R4: The threshold level for code n is 61 − 4·n bytes, so code 0 gives 61 and code 15 gives 1. The threshold flag is high exactly when the count is greater than or equal to that level. The flag follows a code change with no cycle of delay.
- R5: A read while the count is 0 leaves the count at 0. It sets the underflow flag, and the flag stays high until a flush.
- R6: A write without a read while the count is 64 keeps the count at 64, discards the oldest unread byte and appends the new byte at the tail. It also sets the overflow flag, which stays high until a flush.
- R7: A flush takes priority over any write or read in the same cycle. On the next cycle the count is 0 and both error flags are low.
- R8: A simultaneous write and read at count 64 keeps the count at 64 and does not set overflow. A simultaneous write and read at count 0 stores the byte, gives a count of 1 and sets underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous empty and error-flag clear |
| wr_en_i | input | 1 | Write strobe from the host side |
| wr_data_i | input | 8 | Byte to store |
| rd_en_i | input | 1 | Read strobe from the modulator side |
| rd_data_o | output | 8 | Oldest unread byte (show-ahead) |
| thr_code_i | input | 4 | Threshold level code |
| count_o | output | 7 | Number of stored bytes, 0 to 64 |
| thr_flag_o | output | 1 | Count is at or above the selected level |
| underflow_o | output | 1 | Sticky: a read was made while empty |
| overflow_o | output | 1 | Sticky: a write was made while full |

## Verification
The assertions assume that the strobes and the threshold code are driven to known values in every cycle after reset, and that flush is a single-cycle synchronous request rather than a level held across reset. The stimulus changes every input just after a rising edge and holds it for the whole cycle. It drives the queue deliberately into the empty and full corners, and it makes simultaneous reads and writes there, because those are the cycles where the count and the error flags diverge from the plain increment and decrement behaviour.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  parameter int unsigned THR_W      = 4;
  parameter int unsigned THR_STEP   = 4;
  parameter int unsigned THR_MARGIN = 3;
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_fifo_ctrl.sv
module tx_fifo_ctrl #(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic             mem_we_o,
  output logic [AW-1:0]    wr_ptr_o,
  output logic [AW-1:0]    rd_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             uf_q, of_q;
  logic             empty, full, rd_ok, wr_ovf, wr_grow;

  assign empty   = (count_q == '0);
  assign full    = (count_q == FULL_CNT);
  assign rd_ok   = rd_en_i & ~empty;
  // write into a full queue with no pop: drop oldest entry
  assign wr_ovf  = wr_en_i & full & ~rd_ok;
  assign wr_grow = wr_en_i & ~wr_ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      uf_q     <= 1'b0;
      of_q     <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      uf_q     <= 1'b0;
      of_q     <= 1'b0;
    end else begin
      if (wr_en_i)         wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_ok || wr_ovf) rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({wr_grow, rd_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (rd_en_i && empty) uf_q <= 1'b1;
      if (wr_ovf)           of_q <= 1'b1;
    end
  end

  assign mem_we_o    = wr_en_i & ~flush_i;
  assign wr_ptr_o    = wr_ptr_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign count_o     = count_q;
  assign underflow_o = uf_q;
  assign overflow_o  = of_q;
endmodule

// File: rtl/tx_fifo_thresh.sv
module tx_fifo_thresh
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [THR_W-1:0] thr_code_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             thr_flag_o
);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(DEPTH - THR_MARGIN);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(THR_STEP);

  logic [CNT_W-1:0] level;

  always_comb begin
    level      = TOP - STEP * CNT_W'(thr_code_i);
    thr_flag_o = (count_i >= level);
  end
endmodule

// File: rtl/tx_fifo.sv
module tx_fifo
  import tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [THR_W-1:0]  thr_code_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              thr_flag_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  logic          mem_we;
  logic [AW-1:0] wr_ptr, rd_ptr;

  tx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .mem_we_o    (mem_we),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .count_o     (count_o),
    .underflow_o (underflow_o),
    .overflow_o  (overflow_o)
  );

  tx_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (wr_ptr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (rd_data_o)
  );

  tx_fifo_thresh #(.DEPTH(DEPTH)) u_thresh (
    .thr_code_i (thr_code_i),
    .count_i    (count_o),
    .thr_flag_o (thr_flag_o)
  );
endmodule

// File: rtl/tx_fifo_chk.sv
module tx_fifo_chk #(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             thr_flag_o,
  input logic             underflow_o,
  input logic             overflow_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // R1
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);

  // R3
  count_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && !flush_i && count_o != FULL_CNT)
      |=> count_o == $past(count_o) + 1'b1);

  // R3
  count_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && rd_en_i && !flush_i && count_o != '0)
      |=> count_o == $past(count_o) - 1'b1);

  // R4
  thr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> !thr_flag_o);

  // R4
  thr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == FULL_CNT) |-> thr_flag_o);

  // R5
  underflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !flush_i && count_o == '0) |=> underflow_o);

  // R5
  underflow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !flush_i) |=> underflow_o);

  // R6
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && !flush_i && count_o == FULL_CNT)
      |=> overflow_o && count_o == FULL_CNT);

  // R7
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0) && !underflow_o && !overflow_o);

  // R8
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i && !flush_i && !overflow_o && count_o == FULL_CNT)
      |=> !overflow_o && count_o == FULL_CNT);
endmodule

bind tx_fifo tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .count_o     (count_o),
  .thr_flag_o  (thr_flag_o),
  .underflow_o (underflow_o),
  .overflow_o  (overflow_o)
);

// File: tb/tb_tx_fifo.sv
module tb_tx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flush_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [3:0] thr_code_i = 4'd15;
  logic [6:0] count_o;
  logic       thr_flag_o, underflow_o, overflow_o;

  tx_fifo dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int   n_chk = 0;
  int   n_fail = 0;
  logic [7:0] mq[$];   // model contents
  logic [7:0] rdq[$];  // expected read data this cycle
  bit   m_uf = 0, m_of = 0;
  string prev_tag = "R1";

  task automatic expect_eq(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares with show-ahead output
  always @(negedge clk_i) begin
    if (rst_ni && rd_en_i && !flush_i && rdq.size() > 0) begin
      logic [7:0] e;
      e = rdq.pop_front();
      expect_eq("R2", "rd_data", int'(rd_data_o), int'(e));
    end
  end

  task automatic check_state(input string tag);
    int lvl;
    lvl = 61 - 4 * int'(thr_code_i);
    expect_eq(tag, "count", int'(count_o), mq.size());
    expect_eq(tag, "thr_flag", int'(thr_flag_o), int'(mq.size() >= lvl));
    expect_eq(tag, "underflow", int'(underflow_o), int'(m_uf));
    expect_eq(tag, "overflow", int'(overflow_o), int'(m_of));
  endtask

  // driver: checks the outcome of the previous cycle, then applies new inputs
  task automatic cyc(input bit wr, input logic [7:0] d, input bit rd,
                     input bit fl, input logic [3:0] code, input string tag);
    bit rd_ok;
    int sz;
    @(posedge clk_i); #1;
    check_state(prev_tag);
    wr_en_i = wr; wr_data_i = d; rd_en_i = rd; flush_i = fl; thr_code_i = code;
    #1;
    // R4: flag follows the code combinationally
    check_state(tag);
    sz = mq.size();
    if (fl) begin
      mq.delete(); m_uf = 0; m_of = 0;
    end else begin
      rd_ok = rd && sz > 0;
      if (rd && sz == 0) m_uf = 1;
      if (rd_ok) begin
        rdq.push_back(mq[0]);
        void'(mq.pop_front());
      end
      if (wr) begin
        if (sz == DEPTH && !rd_ok) begin
          m_of = 1;
          void'(mq.pop_front());
        end
        mq.push_back(d);
      end
    end
    prev_tag = tag;
  endtask

  task automatic idle(input logic [3:0] code, input string tag);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, code, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_ni = 1'b1;
    idle(4'd15, "R1");
    // R3 writes, then mixed write/read, R2 order
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'h10 + 8'(i), 1'b0, 1'b0, 4'd15, "R3");
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'h20 + 8'(i), 1'b1, 1'b0, 4'd14, "R3");
    // R4 sweep with count 5
    for (int c = 0; c < 16; c++) idle(4'(c), "R4");
    // drain, then R5 underflow on empty
    for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 4'd15, "R2");
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 4'd15, "R5");
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 4'd15, "R5");
    idle(4'd15, "R5");
    // R7 flush beats same-cycle write
    cyc(1'b1, 8'hEE, 1'b0, 1'b1, 4'd15, "R7");
    idle(4'd15, "R7");
    // fill to 64 with code 0 (level 61)
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 8'(8'h40 + i), 1'b0, 1'b0, 4'd0, "R4");
    // R8 swap at full
    cyc(1'b1, 8'hA0, 1'b1, 1'b0, 4'd0, "R8");
    idle(4'd0, "R8");
    // R6 overflow drops oldest
    cyc(1'b1, 8'hB1, 1'b0, 1'b0, 4'd0, "R6");
    cyc(1'b1, 8'hB2, 1'b0, 1'b0, 4'd0, "R6");
    idle(4'd0, "R6");
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 4'd0, "R2");
    idle(4'd15, "R6");
    // R8 write+read at empty
    cyc(1'b1, 8'hC3, 1'b1, 1'b0, 4'd15, "R8");
    idle(4'd15, "R8");
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 4'd15, "R2");
    // R7 flush with pending data and both flags set
    cyc(1'b1, 8'h01, 1'b0, 1'b0, 4'd15, "R7");
    cyc(1'b0, 8'h00, 1'b1, 1'b1, 4'd15, "R7");
    idle(4'd15, "R7");
    idle(4'd15, "R7");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule